// File: doc/BRIEF.md
# Nine-Bit Symbol Error Patcher

This block applies the corrections from a Reed-Solomon decoder to a 512-byte data block. The block sits in a byte-wide local RAM. The data is one little-endian bit stream, cut into 9-bit symbols that are packed with no gaps. Most symbols therefore straddle two bytes. For each reported error, the block fetches the two bytes that hold the symbol and treats them as a 16-bit word. It XORs the 9-bit mask in at the computed bit offset and stores both bytes again.

A single `start` pulse samples the decoder status and the table of index/mask pairs. The status is an error-present bit, an uncorrectable bit and an error count. The block then walks the reported errors in ascending order and raises `done`. When the decoder reports the block as uncorrectable, the patcher touches nothing and raises `err_flag` together with `done`. The RAM port has a one-cycle read latency.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for `start`.
- `ST_CHECK`: decides among `ST_FAIL`, `ST_DONE` and `ST_LOCATE`.
- `ST_LOCATE`: computes the byte pair and the offset. It goes to `ST_RD_LO`, or to `ST_ADVANCE` when the entry is skipped.
- `ST_RD_LO`, `ST_RD_HI`, `ST_CATCH`: issue the two reads and capture the returned bytes.
- `ST_MODIFY`: applies the XOR.
- `ST_WR_LO`, `ST_WR_HI`: store the two bytes.
- `ST_ADVANCE`: goes back to `ST_LOCATE` for the next entry, or on to `ST_DONE`.

`ST_DONE` and `ST_FAIL` hold their outputs until the next `start`, which leads to `ST_CHECK`.

Top module: `symfix_top`

## Requirements
- R1: Symbol k (k ≥ 1) covers absolute stream bits 9(k-1) to 9k-1. Absolute bit a is bit (a mod 8) of byte a/8.
- R2: Applying entry (k, mask) inverts absolute bit 9(k-1)+m for every set mask bit m (0..8). No other RAM bit changes.
- R3: An entry is skipped with no RAM access if k = 0, or if its upper byte index ((9k-1)>>3) is 512 or more. With the default parameters that is k ≥ 456.
- R4: If the uncorrectable bit is set when `start` is sampled, the block raises `err_flag` and `done` two edges after the start edge and makes no RAM access. This holds whatever the other fields are.
- R5: If the uncorrectable bit is clear and the error-present bit is clear, `done` rises on the second clock edge after the start edge. `err_flag` stays low and no RAM access is made.
- R6: With count c, table entries 0 to min(c, 4)-1 are applied in ascending order, and later entries have no effect. Entry e occupies `err_idx_all[e*10 +: 10]` and `err_mask_all[e*9 +: 9]`.
- R7: Each applied entry makes exactly two reads followed by exactly two writes. The writes go first to the lower byte, then to the upper byte at the next address. Read and write enables are never high together.
- R8: `done` and `err_flag` hold until the next `start`. A `start` while a job is running is ignored.
- R9: After reset, `done`, `err_flag`, `ram_rd_en` and `ram_wr_en` are low.
- R10: The status inputs and the entry table are sampled only on the start edge. Changing them afterwards has no effect on the job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job, sampled in idle, done or fail state |
| st_present | input | 1 | Decoder reports errors |
| st_uncorr | input | 1 | Decoder reports an uncorrectable block |
| st_count | input | 3 | Number of reported errors |
| err_idx_all | input | 40 | Four packed 10-bit symbol indices |
| err_mask_all | input | 36 | Four packed 9-bit masks |
| ram_addr | output | 9 | RAM byte address |
| ram_rd_en | output | 1 | RAM read strobe, data valid the next cycle |
| ram_rdata | input | 8 | RAM read data |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| done | output | 1 | Job finished |
| err_flag | output | 1 | Job refused as uncorrectable |

## Verification
Every symbol index from 0 to 1023 is applied alone with a mask that varies with the index. This covers all eight bit offsets, the offset-7 wrap case and the last in-range symbol. It also covers index 0 and the indices just past the block end, which must leave the RAM unchanged. Multi-entry jobs with counts from 1 to 7 use pseudo-random tables, including repeated symbols. These separate correct ascending application, the ignoring of entries past the count, and count clamping from a design that applies the wrong or too many entries. Jobs where the decoder reports no errors, or an uncorrectable block, check the exact `done` timing and the absence of any RAM access. The inputs are scrambled right after every start, which shows that only the start-edge values are used.

// File: rtl/symfix_pkg.sv
package symfix_pkg;

    localparam int SYM_W = 9;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LOCATE,
        ST_RD_LO,
        ST_RD_HI,
        ST_CATCH,
        ST_MODIFY,
        ST_WR_LO,
        ST_WR_HI,
        ST_ADVANCE,
        ST_DONE,
        ST_FAIL
    } fix_state_e;

endpackage

// File: rtl/symfix_locator.sv
module symfix_locator #(
    parameter int DATA_BYTES = 512,
    parameter int IDX_W      = 10,
    localparam int PW        = IDX_W + 4,
    localparam int HW        = PW - 3
) (
    input  logic [IDX_W-1:0] sym_idx,
    output logic [HW-1:0]    hi_byte,
    output logic [2:0]       bit_off,
    output logic             skip
);

    logic [PW-1:0] end_pos;
    logic [HW-1:0] base;

    always_comb begin
        // position just past the symbol's last bit
        end_pos = PW'(sym_idx) * PW'(9);
        base    = end_pos[PW-1:3];
        if (end_pos[2:0] == 3'd0) begin
            hi_byte = base - HW'(1);
            bit_off = 3'd7;
        end else begin
            hi_byte = base;
            bit_off = end_pos[2:0] - 3'd1;
        end
        skip = (sym_idx == '0) || (hi_byte >= HW'(DATA_BYTES));
    end

endmodule

// File: rtl/symfix_merge.sv
module symfix_merge
    import symfix_pkg::*;
(
    input  logic [15:0]      word_in,
    input  logic [SYM_W-1:0] mask,
    input  logic [2:0]       bit_off,
    output logic [15:0]      word_out
);

    logic [15:0] flip;

    always_comb begin
        flip     = {7'd0, mask} << bit_off;
        word_out = word_in ^ flip;
    end

endmodule

// File: rtl/symfix_top.sv
module symfix_top
    import symfix_pkg::*;
#(
    parameter int DATA_BYTES = 512,
    parameter int NERR       = 4,
    parameter int IDX_W      = 10,
    parameter int CNT_W      = 3,
    localparam int AW        = $clog2(DATA_BYTES),
    localparam int CW        = $clog2(NERR + 1),
    localparam int HW        = IDX_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    st_present,
    input  logic                    st_uncorr,
    input  logic [CNT_W-1:0]        st_count,
    input  logic [NERR*IDX_W-1:0]   err_idx_all,
    input  logic [NERR*SYM_W-1:0]   err_mask_all,
    output logic [AW-1:0]           ram_addr,
    output logic                    ram_rd_en,
    input  logic [7:0]              ram_rdata,
    output logic                    ram_wr_en,
    output logic [7:0]              ram_wdata,
    output logic                    done,
    output logic                    err_flag
);

    fix_state_e st, st_nx;

    logic [IDX_W-1:0] idx_in  [NERR];
    logic [SYM_W-1:0] mask_in [NERR];
    logic [IDX_W-1:0] idx_q   [NERR];
    logic [SYM_W-1:0] mask_q  [NERR];

    logic [CW-1:0]    cur_q, napply_q, napply_in;
    logic             pres_q, unc_q;
    logic [AW-1:0]    hi_q;
    logic [2:0]       off_q;
    logic [7:0]       lo_byte_q, hi_byte_q;
    logic [15:0]      word_q, word_fixed;
    logic [IDX_W-1:0] cur_idx;
    logic [SYM_W-1:0] cur_mask;
    logic [HW-1:0]    loc_hi;
    logic [2:0]       loc_off;
    logic             loc_skip;
    logic             accept;
    logic             last_entry;

    for (genvar e = 0; e < NERR; e++) begin : g_unpack
        assign idx_in[e]  = err_idx_all[e*IDX_W +: IDX_W];
        assign mask_in[e] = err_mask_all[e*SYM_W +: SYM_W];
    end

    assign napply_in  = (st_count > CNT_W'(NERR)) ? CW'(NERR) : CW'(st_count);
    assign accept     = start && (st == ST_IDLE || st == ST_DONE || st == ST_FAIL);
    assign last_entry = (cur_q + CW'(1)) >= napply_q;

    always_comb begin
        cur_idx  = '0;
        cur_mask = '0;
        for (int e = 0; e < NERR; e++) begin
            if (cur_q == CW'(e)) begin
                cur_idx  = idx_q[e];
                cur_mask = mask_q[e];
            end
        end
    end

    symfix_locator #(
        .DATA_BYTES (DATA_BYTES),
        .IDX_W      (IDX_W)
    ) u_locator (
        .sym_idx (cur_idx),
        .hi_byte (loc_hi),
        .bit_off (loc_off),
        .skip    (loc_skip)
    );

    symfix_merge u_merge (
        .word_in  ({hi_byte_q, lo_byte_q}),
        .mask     (cur_mask),
        .bit_off  (off_q),
        .word_out (word_fixed)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE, ST_DONE, ST_FAIL: if (accept) st_nx = ST_CHECK;
            ST_CHECK: begin
                if (unc_q)                            st_nx = ST_FAIL;
                else if (!pres_q || napply_q == '0)   st_nx = ST_DONE;
                else                                  st_nx = ST_LOCATE;
            end
            ST_LOCATE:  st_nx = loc_skip ? ST_ADVANCE : ST_RD_LO;
            ST_RD_LO:   st_nx = ST_RD_HI;
            ST_RD_HI:   st_nx = ST_CATCH;
            ST_CATCH:   st_nx = ST_MODIFY;
            ST_MODIFY:  st_nx = ST_WR_LO;
            ST_WR_LO:   st_nx = ST_WR_HI;
            ST_WR_HI:   st_nx = ST_ADVANCE;
            ST_ADVANCE: st_nx = last_entry ? ST_DONE : ST_LOCATE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // job and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pres_q    <= 1'b0;
            unc_q     <= 1'b0;
            napply_q  <= '0;
            cur_q     <= '0;
            hi_q      <= '0;
            off_q     <= '0;
            lo_byte_q <= '0;
            hi_byte_q <= '0;
            word_q    <= '0;
            for (int e = 0; e < NERR; e++) begin
                idx_q[e]  <= '0;
                mask_q[e] <= '0;
            end
        end else begin
            if (accept) begin
                pres_q   <= st_present;
                unc_q    <= st_uncorr;
                napply_q <= napply_in;
                cur_q    <= '0;
                for (int e = 0; e < NERR; e++) begin
                    idx_q[e]  <= idx_in[e];
                    mask_q[e] <= mask_in[e];
                end
            end
            unique case (st)
                ST_LOCATE: begin
                    hi_q  <= loc_hi[AW-1:0];
                    off_q <= loc_off;
                end
                ST_RD_HI:   lo_byte_q <= ram_rdata;
                ST_CATCH:   hi_byte_q <= ram_rdata;
                ST_MODIFY:  word_q    <= word_fixed;
                ST_ADVANCE: if (!last_entry) cur_q <= cur_q + CW'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ram_addr  = '0;
        ram_rd_en = 1'b0;
        ram_wr_en = 1'b0;
        ram_wdata = '0;
        done      = 1'b0;
        err_flag  = 1'b0;
        unique case (st)
            ST_RD_LO: begin
                ram_addr  = hi_q - AW'(1);
                ram_rd_en = 1'b1;
            end
            ST_RD_HI: begin
                ram_addr  = hi_q;
                ram_rd_en = 1'b1;
            end
            ST_WR_LO: begin
                ram_addr  = hi_q - AW'(1);
                ram_wr_en = 1'b1;
                ram_wdata = word_q[7:0];
            end
            ST_WR_HI: begin
                ram_addr  = hi_q;
                ram_wr_en = 1'b1;
                ram_wdata = word_q[15:8];
            end
            ST_DONE: done = 1'b1;
            ST_FAIL: begin
                done     = 1'b1;
                err_flag = 1'b1;
            end
            default: ;
        endcase
    end

    // writes issued since the last accepted start
    logic [7:0] wr_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         wr_cnt <= '0;
        else if (accept)    wr_cnt <= '0;
        else if (ram_wr_en) wr_cnt <= wr_cnt + 8'd1;
    end

    assert_wr_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_wr_en && st == ST_WR_LO) |=> (ram_wr_en && ram_addr == $past(ram_addr) + AW'(1)));

    assert_rw_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd_en && ram_wr_en));

    assert_fail_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (done && !ram_rd_en && !ram_wr_en));

    assert_done_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(err_flag)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= 8'(2 * NERR));

    assert_uncorr_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> !unc_q);

endmodule

// File: tb/symfix_top_tb.sv
module symfix_top_tb;

    localparam int NB = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        st_present = 1'b0;
    logic        st_uncorr = 1'b0;
    logic [2:0]  st_count = '0;
    logic [39:0] err_idx_all = '0;
    logic [35:0] err_mask_all = '0;
    logic [8:0]  ram_addr;
    logic        ram_rd_en;
    logic [7:0]  ram_rdata;
    logic        ram_wr_en;
    logic [7:0]  ram_wdata;
    logic        done;
    logic        err_flag;

    logic [7:0] mem [NB];
    logic [7:0] ref_mem [NB];

    int n_checks = 0;
    int n_fails  = 0;
    int wr_seen, rd_seen, order_bad;
    int last_wr;
    logic clr_mon = 1'b0;

    int jk [4];
    int jm [4];

    always #4 clk = ~clk;

    symfix_top u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .st_present(st_present), .st_uncorr(st_uncorr), .st_count(st_count),
        .err_idx_all(err_idx_all), .err_mask_all(err_mask_all),
        .ram_addr(ram_addr), .ram_rd_en(ram_rd_en), .ram_rdata(ram_rdata),
        .ram_wr_en(ram_wr_en), .ram_wdata(ram_wdata),
        .done(done), .err_flag(err_flag)
    );

    // RAM model: one-cycle read latency
    always @(posedge clk) begin
        if (ram_wr_en) mem[ram_addr] <= ram_wdata;
        if (ram_rd_en) ram_rdata <= mem[ram_addr];
    end

    // access monitor
    always @(posedge clk) begin
        if (clr_mon) begin
            wr_seen = 0; rd_seen = 0; order_bad = 0; last_wr = -1;
        end else begin
            if (ram_rd_en) rd_seen++;
            if (ram_wr_en) begin
                if ((wr_seen % 2) == 1 && int'(ram_addr) != last_wr + 1) order_bad++;
                last_wr = int'(ram_addr);
                wr_seen++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit entry_live(input int k);
        return (k != 0) && (((9 * k - 1) >> 3) < NB);
    endfunction

    task automatic ref_apply(input int k, input int m);
        if (entry_live(k)) begin
            for (int b = 0; b < 9; b++) begin
                if (m[b]) begin
                    int a = 9 * (k - 1) + b;
                    ref_mem[a >> 3][a & 7] = ~ref_mem[a >> 3][a & 7];
                end
            end
        end
    endtask

    task automatic compare_ram(input string req);
        int bad = 0, first = -1;
        for (int a = 0; a < NB; a++)
            if (mem[a] !== ref_mem[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        check(bad == 0, req, (first < 0) ? 0 : int'(mem[first]),
              (first < 0) ? 0 : int'(ref_mem[first]));
    endtask

    // runs one job from jk/jm; scrambles the inputs after the start edge (R10)
    task automatic run_job(input bit pres, input bit unc, input int cnt, input string req);
        int live = 0, napp, waited = 0;
        @(negedge clk);
        st_present = pres; st_uncorr = unc; st_count = 3'(cnt);
        for (int e = 0; e < 4; e++) begin
            err_idx_all[e*10 +: 10] = 10'(jk[e]);
            err_mask_all[e*9 +: 9]  = 9'(jm[e]);
        end
        start = 1'b1; clr_mon = 1'b1;
        @(negedge clk);
        start = 1'b0; clr_mon = 1'b0;
        st_present = ~pres; st_uncorr = 1'b0; st_count = 3'd4;
        err_idx_all = 40'h12345_6789A; err_mask_all = 36'hF_FFFF_FFFF;
        while (!done && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        check(done === 1'b1, {req, " done"}, int'(done), 1);
        napp = (cnt > 4) ? 4 : cnt;
        if (pres && !unc)
            for (int e = 0; e < napp; e++) begin
                ref_apply(jk[e], jm[e]);
                if (entry_live(jk[e])) live++;
            end
        check(wr_seen == 2 * live && rd_seen == 2 * live && order_bad == 0,
              "R7 access count/order", wr_seen, 2 * live);
        compare_ram(req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : stim
        int seed = 17;
        for (int a = 0; a < NB; a++) begin
            mem[a] = 8'(a * 37 + 5);
            ref_mem[a] = 8'(a * 37 + 5);
        end
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!done && !err_flag && !ram_rd_en && !ram_wr_en, "R9 reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !err_flag, "R9 after release", int'(done), 0);

        // R5 exact timing, no access
        for (int e = 0; e < 4; e++) begin jk[e] = 10 + e; jm[e] = 9'h1FF; end
        @(negedge clk);
        st_present = 1'b0; st_uncorr = 1'b0; st_count = 3'd4;
        start = 1'b1; clr_mon = 1'b1;
        @(negedge clk);
        start = 1'b0; clr_mon = 1'b0;
        check(done === 1'b0, "R5 not yet done", int'(done), 0);
        @(negedge clk);
        check(done === 1'b1 && err_flag === 1'b0, "R5 done second edge", int'(done), 1);
        check(wr_seen == 0 && rd_seen == 0, "R5 no access", wr_seen + rd_seen, 0);
        compare_ram("R5 ram");

        // R4 uncorrectable: exact timing and no access
        @(negedge clk);
        st_present = 1'b1; st_uncorr = 1'b1; st_count = 3'd4;
        start = 1'b1; clr_mon = 1'b1;
        @(negedge clk);
        start = 1'b0; clr_mon = 1'b0;
        @(negedge clk);
        check(err_flag === 1'b1 && done === 1'b1, "R4 flag", int'(err_flag), 1);
        repeat (5) @(negedge clk);
        check(err_flag === 1'b1 && done === 1'b1, "R8 held", int'(err_flag), 1);
        check(wr_seen == 0 && rd_seen == 0, "R4 no access", wr_seen + rd_seen, 0);
        compare_ram("R4 ram");

        // R1 R2 R3: every index alone
        for (int k = 0; k < 1024; k++) begin
            jk[0] = k; jm[0] = ((k * 91) + 1) & 9'h1FF;
            for (int e = 1; e < 4; e++) begin jk[e] = 7 + e; jm[e] = 9'h1FF; end
            run_job(1'b1, 1'b0, 1, entry_live(k) ? "R1 R2 single" : "R3 skipped");
        end

        // R6 multiple entries, counts 0..7, repeats allowed
        for (int t = 0; t < 300; t++) begin
            for (int e = 0; e < 4; e++) begin
                seed = seed * 1103515245 + 12345;
                jk[e] = (seed >>> 8) & 511;
                if (t % 5 == 0 && e == 1) jk[e] = jk[0];
                jm[e] = ((seed >>> 20) & 9'h1FF) | 1;
            end
            run_job(1'b1, 1'b0, t % 8, "R6 multi");
        end

        // R8: start while busy is ignored
        jk[0] = 40; jm[0] = 9'h155; jk[1] = 41; jm[1] = 9'h0AA;
        @(negedge clk);
        st_present = 1'b1; st_uncorr = 1'b0; st_count = 3'd2;
        err_idx_all = '0; err_mask_all = '0;
        err_idx_all[9:0] = 10'd40; err_idx_all[19:10] = 10'd41;
        err_mask_all[8:0] = 9'h155; err_mask_all[17:9] = 9'h0AA;
        start = 1'b1; clr_mon = 1'b1;
        @(negedge clk);
        clr_mon = 1'b0; st_uncorr = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        ref_apply(40, 9'h155); ref_apply(41, 9'h0AA);
        check(done === 1'b1 && err_flag === 1'b0, "R8 busy start", int'(err_flag), 0);
        compare_ram("R8 ram");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule